// File: doc/BRIEF.md
# Address Translation Unit with Hardware Page-Table Refill

This block turns virtual addresses from a processor into physical addresses for loads, stores and instruction fetches. Pages are 1 KB. The low ten bits of the address are never translated. The upper bits, the virtual page number, select one entry of a single-level page table in physical memory. A small fully associative translation cache keeps recent page mappings. When a lookup misses, the block forms the entry address itself from a base register and the page number, reads that entry over a simple memory read port, and then completes the request.

Each page table entry is 32 bits. Bit 31 marks the entry valid, bits 30:29 hold the access rights and bits 15:0 hold the physical page number. Before a translation is returned, the access is checked against the page's rights. A missing page and a rights violation each come back as a fault code, with no physical address. Writing the base register selects a different address space, so every cached translation is dropped.

Top module: `xlate_unit`

## Requirements
- R1: A successful response carries `rsp_paddr = {ppn, vaddr[9:0]}`: the page offset passes through unchanged, and the physical page number sits above it.
- R2: On a cache miss, `mem_rd_en` pulses for exactly one cycle, in the cycle after the request is accepted. The address is `ptb + vpn*4`, computed modulo 2^26, where `vpn = vaddr[31:10]` and `ptb` is the base register value at acceptance.
- R3: Entry layout: bit 31 valid, bits 30:29 rights, bits 15:0 physical page number. If a fetched entry has bit 31 clear, the response carries `rsp_fault = 1` (page absent) and `rsp_paddr = 0`.
- R4: Access kinds are 0 = load, 1 = store and 2 = fetch. Rights 00 (read-only) allow a load. Rights 01 (read/write) allow a load or a store. Rights 10 (executable) allow a load or a fetch. Rights 11 allow nothing. A disallowed access returns `rsp_fault = 2` with `rsp_paddr = 0`. `rsp_fault = 0` means success.
- R5: On a hit, `rsp_valid` is high for one cycle, in the cycle right after acceptance, and no memory read is issued. Every accepted request gets exactly one response.
- R6: After a missing request is accepted, `req_ready` stays low until the response is issued.
- R7: An entry fetched with bit 31 clear is never cached, so a repeat access to that page reads memory again.
- R8: An entry fetched with bit 31 set is cached even when the access faulted on rights. Later accesses to that page hit.
- R9: A write to the base register invalidates every cached translation. If the write lands while a table read is in flight, that read still produces its response but is not cached.
- R10: A refill goes into the lowest-numbered empty slot. When all slots are full, the victim is picked by a round-robin pointer, which starts at slot 0 after reset and advances on each such eviction.
- R11: During and right after reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_paddr | output | 26 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 success, 1 page absent, 2 rights violation |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_rd_addr | output | 26 | Page-table entry address |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 32 | Page-table entry |
| ptb_wr_en | input | 1 | Write page-table base register |
| ptb_wr_data | input | 26 | New page-table base |

## Verification
The bound checker watches these rules on every cycle:
- the page offset passes through on successful responses;
- a faulting response carries a zero address;
- the table-read address matches the base and page number captured at acceptance, and the read strobe is a single pulse;
- a response appears only for an accepted request;
- `req_ready` stays low while a table read is outstanding.

The bench's scenarios cover the rest, because it depends on what the cache holds: the hit and miss pattern, the rights table, the refusal to cache absent pages, invalidation by a base write (including one that lands mid-read), and the fill-then-round-robin victim order.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_RIGHTS = 2'd2
  } fault_e;

  localparam logic [1:0] PERM_RO = 2'b00;
  localparam logic [1:0] PERM_RW = 2'b01;
  localparam logic [1:0] PERM_EX = 2'b10;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_WAIT = 1'b1
  } walk_state_e;
endpackage

// File: rtl/xlate_rights.sv
module xlate_rights
  import xlate_pkg::*;
(
  input  logic [1:0] perm,
  input  logic [1:0] kind,
  output logic       allowed
);
  always_comb begin
    case (perm)
      PERM_RO: allowed = (kind == ACC_LOAD);
      PERM_RW: allowed = (kind == ACC_LOAD) || (kind == ACC_STORE);
      PERM_EX: allowed = (kind == ACC_LOAD) || (kind == ACC_FETCH);
      default: allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int VPN_W   = 22,
  parameter int PPN_W   = 16,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [1:0]       lk_rights,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [1:0]       ins_rights
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       rights;
  } slot_t;

  slot_t              slots [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] occupied;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   free_idx;
  logic               free_found;
  logic [IDX_W-1:0]   victim;

  // One tag comparator per slot.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g]    = slots[g].vld && (slots[g].tag == lk_vpn);
    assign occupied[g] = slots[g].vld;
  end

  // At most one slot can match, so the hit data is an OR of the masked slots.
  always_comb begin
    lk_ppn    = '0;
    lk_rights = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_ppn    = lk_ppn    | (slots[i].ppn    & {PPN_W{match[i]}});
      lk_rights = lk_rights | (slots[i].rights & {2{match[i]}});
    end
  end
  assign lk_hit = |match;

  // Lowest-numbered empty slot wins; otherwise fall back to the pointer.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occupied[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end
  assign victim = free_found ? free_idx : rr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
      rr_ptr <= '0;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) slots[i].vld <= 1'b0;
    end else if (ins_en) begin
      slots[victim] <= '{vld: 1'b1, tag: ins_vpn, ppn: ins_ppn, rights: ins_rights};
      if (!free_found) begin
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 26,
  parameter int OFS_W = 10,
  parameter int PPN_W = 16,
  parameter int PTE_W = 32,
  parameter int VPN_W = VA_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  input  logic [PA_W-1:0]  ptb,
  input  logic             flush,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  logic [PPN_W-1:0] lk_ppn,
  input  logic [1:0]       lk_rights,
  output logic             ins_en,
  output logic [VPN_W-1:0] ins_vpn,
  output logic [PPN_W-1:0] ins_ppn,
  output logic [1:0]       ins_rights
);
  localparam int V_BIT  = PTE_W - 1;
  localparam int R_HI   = PTE_W - 2;
  localparam int SPARE  = PTE_W - 3 - PPN_W;

  walk_state_e      state;
  logic [VPN_W-1:0] pend_vpn;
  logic [OFS_W-1:0] pend_ofs;
  logic [1:0]       pend_kind;
  logic             keep_fill;

  logic             accept;
  logic             pte_v;
  logic [1:0]       pte_r;
  logic [PPN_W-1:0] pte_ppn;
  logic [SPARE-1:0] pte_unused;
  logic [1:0]       chk_perm;
  logic [1:0]       chk_kind;
  logic             perm_ok;
  logic [PA_W-1:0]  walk_addr;

  assign req_ready  = (state == WS_IDLE);
  assign accept     = req_valid && req_ready;
  assign lk_vpn     = req_vaddr[VA_W-1:OFS_W];

  assign pte_v      = mem_rd_data[V_BIT];
  assign pte_r      = mem_rd_data[R_HI -: 2];
  assign pte_ppn    = mem_rd_data[PPN_W-1:0];
  assign pte_unused = mem_rd_data[PTE_W-4 -: SPARE];

  // Entry address: base plus page number scaled by the 4-byte entry size.
  assign walk_addr  = ptb + PA_W'({lk_vpn, 2'b00});

  // One rights checker, fed from the cache on a hit or from memory on a refill.
  assign chk_perm   = (state == WS_IDLE) ? lk_rights : pte_r;
  assign chk_kind   = (state == WS_IDLE) ? req_kind  : pend_kind;

  xlate_rights u_rights (
    .perm    (chk_perm),
    .kind    (chk_kind),
    .allowed (perm_ok)
  );

  assign ins_en     = (state == WS_WAIT) && mem_rd_valid && pte_v && keep_fill && !flush;
  assign ins_vpn    = pend_vpn;
  assign ins_ppn    = pte_ppn;
  assign ins_rights = pte_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WS_IDLE;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= FLT_NONE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      pend_vpn    <= '0;
      pend_ofs    <= '0;
      pend_kind   <= '0;
      keep_fill   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      mem_rd_en <= 1'b0;
      case (state)
        WS_IDLE: begin
          if (accept) begin
            if (lk_hit) begin
              rsp_valid <= 1'b1;
              if (perm_ok) begin
                rsp_paddr <= PA_W'({lk_ppn, req_vaddr[OFS_W-1:0]});
                rsp_fault <= FLT_NONE;
              end else begin
                rsp_paddr <= '0;
                rsp_fault <= FLT_RIGHTS;
              end
            end else begin
              state       <= WS_WAIT;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= walk_addr;
              pend_vpn    <= lk_vpn;
              pend_ofs    <= req_vaddr[OFS_W-1:0];
              pend_kind   <= req_kind;
              keep_fill   <= 1'b1;
            end
          end
        end
        WS_WAIT: begin
          if (flush) keep_fill <= 1'b0;
          if (mem_rd_valid) begin
            state     <= WS_IDLE;
            rsp_valid <= 1'b1;
            if (!pte_v) begin
              rsp_paddr <= '0;
              rsp_fault <= FLT_ABSENT;
            end else if (!perm_ok) begin
              rsp_paddr <= '0;
              rsp_fault <= FLT_RIGHTS;
            end else begin
              rsp_paddr <= PA_W'({pte_ppn, pend_ofs});
              rsp_fault <= FLT_NONE;
            end
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 26,
  parameter int OFS_W   = 10,
  parameter int PPN_W   = 16,
  parameter int PTE_W   = 32,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  input  logic             ptb_wr_en,
  input  logic [PA_W-1:0]  ptb_wr_data
);
  localparam int VPN_W = VA_W - OFS_W;

  logic [PA_W-1:0]  ptb_q;
  logic             flush;
  logic [VPN_W-1:0] lk_vpn;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic [1:0]       lk_rights;
  logic             ins_en;
  logic [VPN_W-1:0] ins_vpn;
  logic [PPN_W-1:0] ins_ppn;
  logic [1:0]       ins_rights;

  assign flush = ptb_wr_en;

  always_ff @(posedge clk) begin
    if (rst)            ptb_q <= '0;
    else if (ptb_wr_en) ptb_q <= ptb_wr_data;
  end

  xlate_tlb #(
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .ENTRIES (ENTRIES)
  ) u_tlb (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .lk_vpn     (lk_vpn),
    .lk_hit     (lk_hit),
    .lk_ppn     (lk_ppn),
    .lk_rights  (lk_rights),
    .ins_en     (ins_en),
    .ins_vpn    (ins_vpn),
    .ins_ppn    (ins_ppn),
    .ins_rights (ins_rights)
  );

  xlate_walker #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .OFS_W (OFS_W),
    .PPN_W (PPN_W),
    .PTE_W (PTE_W),
    .VPN_W (VPN_W)
  ) u_walk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_kind     (req_kind),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .ptb          (ptb_q),
    .flush        (flush),
    .lk_vpn       (lk_vpn),
    .lk_hit       (lk_hit),
    .lk_ppn       (lk_ppn),
    .lk_rights    (lk_rights),
    .ins_en       (ins_en),
    .ins_vpn      (ins_vpn),
    .ins_ppn      (ins_ppn),
    .ins_rights   (ins_rights)
  );
endmodule

// File: rtl/xlate_unit_chk.sv
module xlate_unit_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 26,
  parameter int OFS_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            mem_rd_en,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            mem_rd_valid,
  input logic            ptb_wr_en,
  input logic [PA_W-1:0] ptb_wr_data
);
  logic [VA_W-1:0] last_va;
  logic [PA_W-1:0] ptb_seen;
  logic [PA_W-1:0] ptb_at_acc;
  logic            pending;
  logic            busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_va    <= '0;
      ptb_seen   <= '0;
      ptb_at_acc <= '0;
      pending    <= 1'b0;
      busy       <= 1'b0;
    end else begin
      if (ptb_wr_en) ptb_seen <= ptb_wr_data;
      if (req_valid && req_ready) begin
        last_va    <= req_vaddr;
        ptb_at_acc <= ptb_seen;
        pending    <= 1'b1;
      end else if (rsp_valid) begin
        pending <= 1'b0;
      end
      if (mem_rd_en)         busy <= 1'b1;
      else if (mem_rd_valid) busy <= 1'b0;
    end
  end

  // R1: the page offset of the accepted request reaches the physical address.
  a_r1_offset_through: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'd0) |-> rsp_paddr[OFS_W-1:0] == last_va[OFS_W-1:0]);

  // R2: the table read targets base plus scaled page number.
  a_r2_walk_address: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> mem_rd_addr == ptb_at_acc + PA_W'({last_va[VA_W-1:OFS_W], 2'b00}));

  // R2: the read strobe lasts one cycle.
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R3 and R4: a fault code carries no address, and code 3 is never produced.
  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);

  a_r3_fault_code_legal: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault != 2'd3);

  // R5: a response only answers an accepted request.
  a_r5_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> pending);

  // R6: no request is taken while a table read is outstanding.
  a_r6_ready_low_on_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  a_r6_ready_low_walk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);
endmodule

bind xlate_unit xlate_unit_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFS_W (OFS_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_valid (mem_rd_valid),
  .ptb_wr_en    (ptb_wr_en),
  .ptb_wr_data  (ptb_wr_data)
);

// File: tb/xlate_unit_test.sv
module xlate_unit_test;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [25:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_rd_en;
  logic [25:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        ptb_wr_en = 1'b0;
  logic [25:0] ptb_wr_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [25:0] ptb_cur = '0;
  bit          m_vld [8];
  logic [21:0] m_vpn [8];
  int          m_rr = 0;

  always #5 clk = ~clk;

  xlate_unit uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .ptb_wr_en(ptb_wr_en), .ptb_wr_data(ptb_wr_data)
  );

  function automatic logic [31:0] gen_pte(input logic [25:0] a);
    int unsigned w;
    logic        v;
    logic [1:0]  r;
    logic [15:0] p;
    w = 32'(a >> 2);
    v = (w % 7) != 3;
    r = 2'(w % 4);
    p = 16'(w * 37 + 5);
    return {v, r, 13'd0, p};
  endfunction

  function automatic bit rights_ok(input logic [1:0] r, input logic [1:0] k);
    case (r)
      2'b00:   return k == 2'd0;
      2'b01:   return k == 2'd0 || k == 2'd1;
      2'b10:   return k == 2'd0 || k == 2'd2;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit c, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!c) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Memory model: answers a read strobe LAT cycles later.
  initial begin
    int          cnt;
    logic [25:0] a_l;
    cnt = 0;
    a_l = '0;
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = gen_pte(a_l);
        end
      end
      if (mem_rd_en) begin
        cnt = LAT;
        a_l = mem_rd_addr;
      end
    end
  end

  task automatic write_ptb(input logic [25:0] v);
    @(negedge clk);
    ptb_wr_en   = 1'b1;
    ptb_wr_data = v;
    ptb_cur     = v;
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
    @(negedge clk);
    ptb_wr_en = 1'b0;
  endtask

  task automatic do_req(input logic [31:0] va, input logic [1:0] k,
                        output logic [25:0] pa, output logic [1:0] f,
                        output bit missed, output logic [25:0] maddr, output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_kind  = k;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat    = 1;
    missed = 0;
    maddr  = '0;
    while (!rsp_valid && lat < 100) begin
      if (mem_rd_en) begin
        missed = 1;
        maddr  = mem_rd_addr;
        chk(!req_ready, "R6", "ready during walk", longint'(req_ready), 0);
      end
      @(negedge clk);
      lat++;
    end
    pa = rsp_paddr;
    f  = rsp_fault;
  endtask

  task automatic access(input logic [31:0] va, input logic [1:0] k,
                        input bit no_ins, input string tag);
    logic [21:0] vpn;
    logic [25:0] ea;
    logic [31:0] pte;
    bit          hit;
    logic [1:0]  ef;
    logic [25:0] epa;
    logic [25:0] pa;
    logic [1:0]  f;
    bit          missed;
    logic [25:0] maddr;
    int          lat;
    vpn = va[31:10];
    ea  = ptb_cur + 26'({vpn, 2'b00});
    pte = gen_pte(ea);
    hit = 0;
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_vpn[i] == vpn) hit = 1;
    if (!hit && !pte[31])               ef = 2'd1;
    else if (!rights_ok(pte[30:29], k)) ef = 2'd2;
    else                                ef = 2'd0;
    epa = (ef != 0) ? 26'd0 : {pte[15:0], va[9:0]};
    do_req(va, k, pa, f, missed, maddr, lat);
    chk(missed == !hit, tag, "miss flag", longint'(missed), longint'(!hit));
    if (hit) chk(lat == 1, "R5", "hit latency", lat, 1);
    else     chk(maddr == ea, "R2", "walk address", maddr, ea);
    chk(f == ef, (ef == 2'd1) ? "R3" : "R4", "fault code", f, ef);
    chk(pa == epa, "R1", "physical address", pa, epa);
    if (!hit && pte[31] && !no_ins) begin
      int slot;
      slot = -1;
      for (int i = 7; i >= 0; i--) if (!m_vld[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % 8;
      end
      m_vld[slot] = 1'b1;
      m_vpn[slot] = vpn;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int vl [10];
    int n;
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset values, checked while reset is still asserted.
    chk(req_ready == 1'b1, "R11", "ready in reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", rsp_valid, 0);
    chk(mem_rd_en == 1'b0, "R11", "mem_rd_en in reset", mem_rd_en, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11", "idle after reset",
        {req_ready, rsp_valid}, 2'b10);

    // Sweep of pages, kinds and offsets (R1..R5, R7, R8).
    write_ptb(26'h10000);
    for (int vp = 0; vp < 6; vp++) begin
      for (int rep = 0; rep < 2; rep++) begin
        for (int k = 0; k < 3; k++) begin
          logic [9:0] ofs;
          ofs = 10'((vp * 97 + k * 13 + rep * 5) % 1024);
          access({22'(vp * 3 + 1), ofs}, 2'(k), 1'b0, "R7 R8");
        end
      end
    end
    access({22'd4, 10'h000}, 2'd0, 1'b0, "R1");
    access({22'd4, 10'h3FF}, 2'd0, 1'b0, "R1");
    access({22'd13, 10'h3FF}, 2'd0, 1'b0, "R7");

    // R9: base write drops cached translations.
    write_ptb(26'h20000);
    access({22'd1, 10'h055}, 2'd0, 1'b0, "R9");
    access({22'd1, 10'h056}, 2'd0, 1'b0, "R9");

    // R9: base write during an in-flight read, which must not be cached.
    fork
      access({22'd4, 10'h123}, 2'd0, 1'b1, "R9");
      begin
        repeat (3) @(negedge clk);
        write_ptb(26'h30000);
      end
    join
    access({22'd4, 10'h124}, 2'd0, 1'b0, "R9");

    // R10: fill every slot, then evict in round-robin order.
    write_ptb(26'h40000);
    n = 0;
    for (int c = 200; n < 10; c++) begin
      logic [31:0] p;
      p = gen_pte(ptb_cur + 26'(c * 4));
      if (p[31]) begin
        vl[n] = c;
        n++;
      end
    end
    for (int i = 0; i < 10; i++) access({22'(vl[i]), 10'h010}, 2'd0, 1'b0, "R10");
    for (int i = 2; i < 10; i++) access({22'(vl[i]), 10'h020}, 2'd0, 1'b0, "R10");
    access({22'(vl[0]), 10'h030}, 2'd0, 1'b0, "R10");
    access({22'(vl[1]), 10'h030}, 2'd0, 1'b0, "R10");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule